// File: doc/BRIEF.md
# 16-bit Pixel Bus Deformatter

This block accepts one 16-bit pixel word per clock and turns it into a full three-component 8-bit pixel. A format select picks one of three packings. Two are packed RGB words, with 5-6-5 or 5-5-5 component widths. The third is 4:2:2 luma/chroma. In that mode the upper byte is luma and the lower byte alternates between the two colour-difference samples. The block rebuilds a co-sited Cb/Cr pair for every pixel, so it emits 4:4:4 data.

Line timing comes from one of two sources. In the first, a free-running pixel index restarts on each rising edge of the horizontal sync input, and active video starts at a programmable pixel offset. In the second, which is only available in luma/chroma mode, the block watches the low byte for embedded timing codes and ignores the sync pin. All outputs are registered. A word sampled at clock edge n appears at the outputs after edge n+1.

Top module: `pix16_deformat`

## Requirements
- R1: While rst_n is low at a clock edge, every output is driven to zero. On release, the chroma phase starts at Cb.
- R2: With fmt_sel = 0 (or the reserved value 3), a word gives R = bits [15:11], G = bits [10:5] and B = bits [4:0]. Each component is widened to 8 bits by copying its top bits below itself. The results appear on pix_c0, pix_c1 and pix_c2.
- R3: With fmt_sel = 2, R = bits [14:10], G = bits [9:5] and B = bits [4:0], each widened to 8 bits by copying its top bits below itself. Bit 15 has no effect on the output.
- R4: With fmt_sel = 1, pix_c0 carries the upper byte of the word as luma. pix_c1 carries Cb and pix_c2 carries Cr.
- R5: In luma/chroma mode, active pixels alternate phase Cb, Cr, Cb, and so on, starting with Cb. A Cb-phase pixel outputs its own low byte as Cb and the low byte of the following word as Cr. A Cr-phase pixel outputs the previous word's low byte as Cb and its own low byte as Cr.
- R6: In sync-pin timing, the word sampled on the same edge as the rising edge of hsync has index 0. The first valid pixel is the word with index equal to sav_offset.
- R7: The index restarts at 0 on every rising edge of hsync, and the chroma phase restarts at Cb with the first active pixel of each line. Before any rising edge of hsync has been seen, no pixel is valid.
- R8: A word sampled at edge n is reported, with pix_valid, right after edge n+1.
- R9: When pix_valid is low, pix_c0, pix_c1 and pix_c2 are zero.
- R10: With fmt_sel = 1 and emb_sync_en = 1, hsync is ignored. Four consecutive low bytes FF, 00, 00, XY with XY bit 7 set form a timing code. If XY bit 4 is 0, the next word is the first active pixel and it takes phase Cb.
- R11: In embedded timing, a low byte of FF on a Cb-phase active word ends active video from that word onward. A code with XY bit 4 set keeps the block inactive.
- R12: In embedded timing, field_flag takes XY bit 6 and vblank_flag takes XY bit 5 of each detected code. Both appear with the same latency as the pixel carrying XY and hold until the next code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | 0: RGB 5-6-5, 1: luma/chroma 4:2:2, 2: RGB 5-5-5, 3: as 0 |
| emb_sync_en | input | 1 | Take line timing from embedded codes (luma/chroma only) |
| hsync | input | 1 | Horizontal sync, active high |
| sav_offset | input | SAV_W | Index of the first active pixel after the hsync edge |
| pix_in | input | 16 | Input pixel word |
| pix_valid | output | 1 | Output pixel is active video |
| pix_c0 | output | 8 | R or Y |
| pix_c1 | output | 8 | G or Cb |
| pix_c2 | output | 8 | B or Cr |
| field_flag | output | 1 | Field bit of the last embedded code |
| vblank_flag | output | 1 | Vertical blanking bit of the last embedded code |

## Verification
The bench checks every output word against a model of each requirement. Its most sensitive points are the chroma phase and the start-of-line position.

A phase register that is off by one swaps Cb and Cr on the very next active pixel. Because every later pixel of that line inherits the error, the check fails two clocks after the faulty word is sampled.

A miscounted index or a wrong sav_offset comparison moves the rising edge of pix_valid. That shows at the first pixel of the line. A missed embedded code leaves pix_valid low through a whole line, and a missed terminator leaves it high on the code words.

// File: rtl/pix16_deformat_pkg.sv
package pix16_deformat_pkg;

    typedef enum logic [1:0] {
        FMT_RGB565 = 2'd0,
        FMT_YCC    = 2'd1,
        FMT_RGB555 = 2'd2,
        FMT_RSVD   = 2'd3
    } pix_fmt_e;

    localparam int WORD_W  = 16;
    localparam int COMP_W  = 8;
    localparam int PRE_LEN = 3;

    localparam logic [COMP_W-1:0] CODE_LEAD = 8'hFF;
    localparam logic [COMP_W-1:0] CODE_ZERO = 8'h00;

    // chroma phase: 0 = Cb slot, 1 = Cr slot
    localparam logic PH_CB = 1'b0;

    function automatic logic [COMP_W-1:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [COMP_W-1:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

endpackage

// File: rtl/pix16_trs_detect.sv
module pix16_trs_detect
    import pix16_deformat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COMP_W-1:0] byte_in,
    output logic              code_hit
);

    typedef struct packed {
        logic [PRE_LEN-1:0][COMP_W-1:0] hist;   // [0] newest
    } det_t;

    det_t det_d, det_q;
    logic [PRE_LEN-1:0] pre_ok;

    // oldest byte must be the lead byte, the rest zero
    generate
        for (genvar k = 0; k < PRE_LEN; k++) begin : g_pre
            if (k == PRE_LEN - 1) begin : g_lead
                assign pre_ok[k] = (det_q.hist[k] == CODE_LEAD);
            end else begin : g_zero
                assign pre_ok[k] = (det_q.hist[k] == CODE_ZERO);
            end
        end
    endgenerate

    always_comb begin
        det_d = det_q;
        det_d.hist[0] = byte_in;
        for (int k = 1; k < PRE_LEN; k++) begin
            det_d.hist[k] = det_q.hist[k-1];
        end
        code_hit = (&pre_ok) && byte_in[7];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

endmodule

// File: rtl/pix16_line_timing.sv
module pix16_line_timing
    import pix16_deformat_pkg::*;
#(
    parameter int SAV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              emb_mode,
    input  logic [SAV_W-1:0]  sav,
    input  logic [WORD_W-1:0] pix_in,
    input  logic              code_hit,
    output logic [WORD_W-1:0] s1_word,
    output logic              s1_act,
    output logic              s1_ph,
    output logic              s1_fld,
    output logic              s1_vbl
);

    localparam int CNT_W = SAV_W + 1;

    typedef struct packed {
        logic              hs;
        logic              seen;
        logic [CNT_W-1:0]  cnt;
        logic              eact;
        logic              eph;
        logic [WORD_W-1:0] word;
        logic              act;
        logic              ph;
        logic              fld;
        logic              vbl;
    } tim_t;

    tim_t tim_d, tim_q;

    logic             hs_rise;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] rel;
    logic             line_ok;
    logic             act_hs;
    logic             term;
    logic             act_em;

    always_comb begin
        hs_rise = hsync & ~tim_q.hs;
        cnt_inc = (tim_q.cnt == {CNT_W{1'b1}}) ? tim_q.cnt : tim_q.cnt + 1'b1;
        idx     = hs_rise ? '0 : cnt_inc;
        line_ok = tim_q.seen | hs_rise;
        rel     = idx - CNT_W'(sav);
        act_hs  = line_ok && (idx >= CNT_W'(sav));
        term    = tim_q.eact && (tim_q.eph == PH_CB) && (pix_in[7:0] == CODE_LEAD);
        act_em  = tim_q.eact && !term;

        tim_d      = tim_q;
        tim_d.hs   = hsync;
        tim_d.seen = line_ok;
        tim_d.cnt  = idx;
        tim_d.word = pix_in;

        if (emb_mode) begin
            tim_d.act  = act_em;
            tim_d.ph   = tim_q.eph;
            tim_d.eact = code_hit ? ~pix_in[4] : (term ? 1'b0 : tim_q.eact);
            tim_d.eph  = code_hit ? PH_CB : ~tim_q.eph;
            if (code_hit) begin
                tim_d.fld = pix_in[6];
                tim_d.vbl = pix_in[5];
            end
        end else begin
            tim_d.act  = act_hs;
            tim_d.ph   = rel[0];
            tim_d.eact = 1'b0;
            tim_d.eph  = PH_CB;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign s1_word = tim_q.word;
    assign s1_act  = tim_q.act;
    assign s1_ph   = tim_q.ph;
    assign s1_fld  = tim_q.fld;
    assign s1_vbl  = tim_q.vbl;

    // R6: zero offset makes the edge word itself active
    p_sav_zero_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!emb_mode && hs_rise && (sav == '0)) |=> s1_act);

    // R5 / R7: a run of active pixels always opens on the Cb slot
    p_run_opens_cb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_act && !$past(s1_act)) |-> (s1_ph == PH_CB));

    // R11: a code with the H bit set leaves the next word inactive
    p_eav_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (emb_mode && code_hit && pix_in[4]) |=> !s1_act);

    // R10: a start code opens active video on the next word
    p_sav_code_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (emb_mode && code_hit && !pix_in[4]) |=> ##1 (s1_act || !$stable(emb_mode)
                                                   || (s1_word[7:0] == CODE_LEAD)));

endmodule

// File: rtl/pix16_unpack.sv
module pix16_unpack
    import pix16_deformat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic [WORD_W-1:0] s1_word,
    input  logic              s1_act,
    input  logic              s1_ph,
    input  logic              s1_fld,
    input  logic              s1_vbl,
    input  logic [COMP_W-1:0] next_low,
    output logic              pix_valid,
    output logic [COMP_W-1:0] pix_c0,
    output logic [COMP_W-1:0] pix_c1,
    output logic [COMP_W-1:0] pix_c2,
    output logic              field_flag,
    output logic              vblank_flag
);

    typedef struct packed {
        logic              vld;
        logic [COMP_W-1:0] c0;
        logic [COMP_W-1:0] c1;
        logic [COMP_W-1:0] c2;
        logic [COMP_W-1:0] cbh;
        logic              fld;
        logic              vbl;
    } out_t;

    out_t out_d, out_q;
    pix_fmt_e fmt;

    always_comb begin
        fmt       = pix_fmt_e'(fmt_sel);
        out_d     = out_q;
        out_d.vld = s1_act;
        out_d.fld = s1_fld;
        out_d.vbl = s1_vbl;
        out_d.c0  = '0;
        out_d.c1  = '0;
        out_d.c2  = '0;
        if (s1_ph == PH_CB) out_d.cbh = s1_word[7:0];

        if (s1_act) begin
            unique case (fmt)
                FMT_YCC: begin
                    out_d.c0 = s1_word[15:8];
                    if (s1_ph == PH_CB) begin
                        out_d.c1 = s1_word[7:0];
                        out_d.c2 = next_low;
                    end else begin
                        out_d.c1 = out_q.cbh;
                        out_d.c2 = s1_word[7:0];
                    end
                end
                FMT_RGB555: begin
                    out_d.c0 = widen5(s1_word[14:10]);
                    out_d.c1 = widen5(s1_word[9:5]);
                    out_d.c2 = widen5(s1_word[4:0]);
                end
                default: begin
                    out_d.c0 = widen5(s1_word[15:11]);
                    out_d.c1 = widen6(s1_word[10:5]);
                    out_d.c2 = widen5(s1_word[4:0]);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pix_valid   = out_q.vld;
    assign pix_c0      = out_q.c0;
    assign pix_c1      = out_q.c1;
    assign pix_c2      = out_q.c2;
    assign field_flag  = out_q.fld;
    assign vblank_flag = out_q.vbl;

    // R8: output flag follows the timing stage by exactly one edge
    p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pix_valid == $past(s1_act)));

    // R9: idle outputs are blank
    p_idle_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_c0 == '0 && pix_c1 == '0 && pix_c2 == '0));

    // R5: a Cr-slot pixel reuses the Cb of its partner
    p_pair_cb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_act && $past(s1_act) && (s1_ph != PH_CB) && (fmt == FMT_YCC)
         && $stable(fmt_sel)) |=> (pix_c1 == $past(s1_word[7:0], 2)));

endmodule

// File: rtl/pix16_deformat.sv
module pix16_deformat
    import pix16_deformat_pkg::*;
#(
    parameter int SAV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              emb_sync_en,
    input  logic              hsync,
    input  logic [SAV_W-1:0]  sav_offset,
    input  logic [15:0]       pix_in,
    output logic              pix_valid,
    output logic [7:0]        pix_c0,
    output logic [7:0]        pix_c1,
    output logic [7:0]        pix_c2,
    output logic              field_flag,
    output logic              vblank_flag
);

    logic              emb_mode;
    logic              code_hit;
    logic [WORD_W-1:0] s1_word;
    logic              s1_act;
    logic              s1_ph;
    logic              s1_fld;
    logic              s1_vbl;

    assign emb_mode = emb_sync_en && (pix_fmt_e'(fmt_sel) == FMT_YCC);

    pix16_trs_detect u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (pix_in[7:0]),
        .code_hit (code_hit)
    );

    pix16_line_timing #(.SAV_W(SAV_W)) u_tim (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync    (hsync),
        .emb_mode (emb_mode),
        .sav      (sav_offset),
        .pix_in   (pix_in),
        .code_hit (code_hit),
        .s1_word  (s1_word),
        .s1_act   (s1_act),
        .s1_ph    (s1_ph),
        .s1_fld   (s1_fld),
        .s1_vbl   (s1_vbl)
    );

    pix16_unpack u_unp (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_sel     (fmt_sel),
        .s1_word     (s1_word),
        .s1_act      (s1_act),
        .s1_ph       (s1_ph),
        .s1_fld      (s1_fld),
        .s1_vbl      (s1_vbl),
        .next_low    (pix_in[7:0]),
        .pix_valid   (pix_valid),
        .pix_c0      (pix_c0),
        .pix_c1      (pix_c1),
        .pix_c2      (pix_c2),
        .field_flag  (field_flag),
        .vblank_flag (vblank_flag)
    );

    // R1: reset clears the visible pixel
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && pix_c0 == '0 && pix_c1 == '0 && pix_c2 == '0
                    && !field_flag && !vblank_flag));

endmodule

// File: tb/pix16_deformat_test.sv
module pix16_deformat_test;

    localparam int SAV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       fmt_sel = 2'd0;
    logic             emb_sync_en = 1'b0;
    logic             hsync = 1'b0;
    logic [SAV_W-1:0] sav_offset = '0;
    logic [15:0]      pix_in = '0;
    logic             pix_valid;
    logic [7:0]       pix_c0, pix_c1, pix_c2;
    logic             field_flag, vblank_flag;

    always #5 clk = ~clk;

    pix16_deformat #(.SAV_W(SAV_W)) uut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .emb_sync_en(emb_sync_en),
        .hsync(hsync), .sav_offset(sav_offset), .pix_in(pix_in),
        .pix_valid(pix_valid), .pix_c0(pix_c0), .pix_c1(pix_c1), .pix_c2(pix_c2),
        .field_flag(field_flag), .vblank_flag(vblank_flag)
    );

    typedef struct {
        logic       v;
        logic [7:0] a, b, c;
        logic       f, vb;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;
    logic [15:0] bw [0:63];
    logic        bh [0:63];
    int          blen = 0;

    // monitor: compares each result two negedges after its word was driven
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (sb.size() > 0 && sb[0].cyc + 2 == cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (pix_valid !== e.v || pix_c0 !== e.a || pix_c1 !== e.b || pix_c2 !== e.c
                    || field_flag !== e.f || vblank_flag !== e.vb) begin
                    n_fail++;
                    $display("FAIL %s: got v=%0b %02h %02h %02h f=%0b vb=%0b, exp v=%0b %02h %02h %02h f=%0b vb=%0b",
                             e.tag, pix_valid, pix_c0, pix_c1, pix_c2, field_flag, vblank_flag,
                             e.v, e.a, e.b, e.c, e.f, e.vb);
                end
            end
        end
    end

    function automatic logic [7:0] grow(input int v, input int bits);
        return 8'((v << (8 - bits)) | (v >> (2 * bits - 8)));
    endfunction

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n  = 1'b0;
        pix_in = '0;
        hsync  = 1'b0;
        sb.delete();
        repeat (2) @(negedge clk);
        n_run++;   // R1: outputs blank while in reset
        if (pix_valid !== 1'b0 || pix_c0 !== 8'h00 || pix_c1 !== 8'h00 || pix_c2 !== 8'h00
            || field_flag !== 1'b0 || vblank_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got v=%0b %02h %02h %02h f=%0b vb=%0b, exp all zero",
                     pix_valid, pix_c0, pix_c1, pix_c2, field_flag, vblank_flag);
        end
        #1 rst_n = 1'b1;
    endtask

    task automatic run_burst(input logic [1:0] f, input logic emb, input int sav, input string tag);
        logic       hsq = 1'b0, seen = 1'b0;
        int         cnt = 0;
        logic       eact = 1'b0, eph = 1'b0;
        logic [7:0] h0 = 8'h00, h1 = 8'h00, h2 = 8'h00;
        logic       fl = 1'b0, vbq = 1'b0;
        fmt_sel     = f;
        emb_sync_en = emb;
        sav_offset  = SAV_W'(sav);
        do_reset();
        for (int i = 0; i < blen; i++) begin
            exp_t       e;
            logic       act, ph;
            logic [7:0] lo, nlo;
            logic [15:0] w;
            if (i > 0) begin
                @(negedge clk); #1;
            end
            w      = bw[i];
            pix_in = w;
            hsync  = bh[i];
            lo     = w[7:0];
            nlo    = (i + 1 < blen) ? bw[i+1][7:0] : bw[blen-1][7:0];
            if (emb && f == 2'd1) begin
                logic hit, term;
                hit  = (h2 == 8'hFF) && (h1 == 8'h00) && (h0 == 8'h00) && lo[7];
                term = eact && !eph && (lo == 8'hFF);
                act  = eact && !term;
                ph   = eph;
                if (hit) begin
                    eact = !lo[4];
                    eph  = 1'b0;
                    fl   = lo[6];
                    vbq  = lo[5];
                end else begin
                    if (term) eact = 1'b0;
                    eph = !eph;
                end
                h2 = h1; h1 = h0; h0 = lo;
            end else begin
                logic rise;
                int   idx;
                rise = bh[i] && !hsq;
                idx  = rise ? 0 : cnt + 1;
                seen = seen || rise;
                act  = seen && (idx >= sav);
                ph   = ((idx - sav) % 2) != 0;
                hsq  = bh[i];
                cnt  = idx;
            end
            e.v = act; e.a = 8'h00; e.b = 8'h00; e.c = 8'h00;
            e.f = fl; e.vb = vbq; e.cyc = cyc; e.tag = tag;
            if (act) begin
                if (f == 2'd1) begin
                    e.a = w[15:8];
                    if (!ph) begin e.b = lo; e.c = nlo; end
                    else     begin e.b = bw[i-1][7:0]; e.c = lo; end
                end else if (f == 2'd2) begin
                    e.a = grow(int'(w[14:10]), 5);
                    e.b = grow(int'(w[9:5]), 5);
                    e.c = grow(int'(w[4:0]), 5);
                end else begin
                    e.a = grow(int'(w[15:11]), 5);
                    e.b = grow(int'(w[10:5]), 6);
                    e.c = grow(int'(w[4:0]), 5);
                end
            end
            sb.push_back(e);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R2 R6 R7 R8 R9: RGB 5-6-5, two hsync edges, offset 3
        blen = 20;
        for (int i = 0; i < blen; i++) begin
            bw[i] = 16'((i * 16'h1357) ^ 16'hA5C3);
            bh[i] = (i == 2 || i == 3 || i == 13 || i == 14);
        end
        bw[5] = 16'hFFFF; bw[6] = 16'h8410; bw[7] = 16'h07E0;
        run_burst(2'd0, 1'b0, 3, "R2 R6 R7 R8 R9");

        // R3: RGB 5-5-5, bit 15 toggled on alternate words
        blen = 14;
        for (int i = 0; i < blen; i++) begin
            bw[i] = 16'((i * 16'h2961) ^ 16'h3C5A) ^ ((i % 2) != 0 ? 16'h8000 : 16'h0000);
            bh[i] = (i == 0);
        end
        bw[4] = 16'h7FFF; bw[5] = 16'hFFFF; bw[6] = 16'h8000;
        run_burst(2'd2, 1'b0, 1, "R3 R8");

        // R2: reserved format code behaves as 5-6-5
        blen = 8;
        for (int i = 0; i < blen; i++) begin
            bw[i] = 16'((i * 16'h4B1D) ^ 16'h0F0F);
            bh[i] = (i == 0);
        end
        run_burst(2'd3, 1'b0, 0, "R2");

        // R4 R5 R6: luma/chroma, offset 2
        blen = 14;
        for (int i = 0; i < blen; i++) begin
            bw[i] = {8'(8'h40 + i), 8'(8'h90 + 3 * i)};
            bh[i] = (i == 0);
        end
        run_burst(2'd1, 1'b0, 2, "R4 R5 R6");

        // R5 R7: luma/chroma, odd line length so phase must restart at Cb
        blen = 14;
        for (int i = 0; i < blen; i++) begin
            bw[i] = {8'(8'h20 + 7 * i), 8'(8'h11 * (i + 1))};
            bh[i] = (i == 1 || i == 6);
        end
        run_burst(2'd1, 1'b0, 0, "R5 R7");

        // R10 R11 R12: embedded codes, hsync toggling but ignored
        blen = 18;
        for (int i = 0; i < blen; i++) begin
            bw[i] = 16'h1010;
            bh[i] = (i % 3) == 0;
        end
        bw[2]  = 16'h10FF; bw[3]  = 16'h1000; bw[4]  = 16'h1000; bw[5]  = 16'h1080;
        bw[6]  = 16'h5140; bw[7]  = 16'h5260; bw[8]  = 16'h5341; bw[9]  = 16'h5461;
        bw[10] = 16'h10FF; bw[11] = 16'h1000; bw[12] = 16'h1000; bw[13] = 16'h10F0;
        run_burst(2'd1, 1'b1, 5, "R10 R11 R12");

        // R12: field set, vblank clear, then short active run
        blen = 12;
        for (int i = 0; i < blen; i++) begin
            bw[i] = 16'h2020;
            bh[i] = 1'b0;
        end
        bw[1] = 16'h20FF; bw[2] = 16'h2000; bw[3] = 16'h2000; bw[4] = 16'h20C0;
        bw[5] = 16'h6A33; bw[6] = 16'h6B44;
        run_burst(2'd1, 1'b1, 0, "R10 R12");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule